// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic reach the configuration registers and statistics counters of an external Ethernet switch over its three-wire serial configuration port. A host issues one request at a time: either a register write (8-bit address, 16-bit value) or a read that names a table (16-bit configuration registers or 32-bit counters) and a 7-bit address. The block builds the command frame, shifts it out most-significant bit first on a slow serial clock and, for reads, turns the data line around and shifts 32 bits back in. A one-cycle `done` pulse closes every request; on reads `rdata` then holds the result.

The serial clock is generated by counting system clock cycles. The half-period and the data setup time are given in nanoseconds and converted with the system clock frequency, so the same block runs from any core clock. Writes frame themselves with chip-select held high; reads use a long run of ones as a preamble and keep chip-select low. Each pin has a separate output value, output enable and (for data) input, so the pad ring decides how the line is shared.

Top module: `swreg_serial_master`

## Requirements
- R1: A write shifts out 27 bits, first to last: 1, 0, 1, the 8 address bits from bit 7 down, then the 16 data bits from bit 15 down; chip-select is high for exactly those 27 rising clock edges and low on all later ones.
- R2: A read shifts out 46 bits, first to last: 32 ones, then 0, 1, 1, 0, the table bit (0 = 16-bit registers, 1 = 32-bit counters), 0, 0, address bits 6 down to 1, and a final 0; chip-select stays low for the whole read.
- R3: The data output only changes while the serial clock is low; it is stable in every cycle the clock is high.
- R4: Every high or low phase of the serial clock lasts at least the edge delay (EDGE_NS converted to cycles, rounded up), and every bit driven before a rising edge is held for at least the setup delay (SETUP_NS converted likewise) before that edge.
- R5: After the 46 command bits of a read, the data output enable is dropped; two idle clock pulses follow, then 32 bits are captured, each sampled just before its rising edge. For table 0, an odd address returns the first 16 bits received, an even address the last 16, zero-extended in `rdata`.
- R6: For table 1, `rdata` is all 32 captured bits, the first received in bit 31.
- R7: Every request ends with two further clock pulses (82 rising edges in all for a read, 29 for a write), after which all three output enables are low when `done` is seen.
- R8: `req_ready` is high only while idle; a request is taken only when `req_valid` and `req_ready` are both high, requests offered while busy are ignored, and `done` is a one-cycle pulse.
- R9: Out of reset all output enables are low, `req_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = read |
| req_table | input | 1 | Read table: 0 = 16-bit registers, 1 = 32-bit counters |
| req_addr | input | 8 | Register address (reads use bits 6..1) |
| req_wdata | input | 16 | Write value |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid from `done` |
| sw_cs_o | output | 1 | Chip-select value |
| sw_cs_oe | output | 1 | Chip-select output enable |
| sw_clk_o | output | 1 | Serial clock value |
| sw_clk_oe | output | 1 | Serial clock output enable |
| sw_dat_o | output | 1 | Serial data value |
| sw_dat_oe | output | 1 | Serial data output enable |
| sw_dat_i | input | 1 | Serial data from the pad |

## Verification
The bench builds the block with a 2 MHz system clock, so the 3000 ns edge delay becomes 6 cycles and the 1000 ns setup delay 2 cycles. With these short delays a full 82-edge read takes about a thousand cycles, which lets every frame be recorded edge by edge against a slave model and lets both address parities, both tables and requests offered mid-transfer be covered in one short run, while the delay counters still span several cycles and the minimum phase lengths can be measured.

// File: rtl/swreg_serial_master.sv
module swreg_serial_master #(
  parameter int CLK_MHZ  = 50,
  parameter int EDGE_NS  = 3000,
  parameter int SETUP_NS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_table,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic [31:0] rdata,
  output logic        sw_cs_o,
  output logic        sw_cs_oe,
  output logic        sw_clk_o,
  output logic        sw_clk_oe,
  output logic        sw_dat_o,
  output logic        sw_dat_oe,
  input  logic        sw_dat_i
);
  localparam int EDGE_RAW  = (EDGE_NS * CLK_MHZ + 999) / 1000;
  localparam int SETUP_RAW = (SETUP_NS * CLK_MHZ + 999) / 1000;
  localparam int EDGE_CYC  = (EDGE_RAW < 1) ? 1 : EDGE_RAW;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int MAX_CYC   = (EDGE_CYC > SETUP_CYC) ? EDGE_CYC : SETUP_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam int FRAME_W   = 46;
  localparam int WR_BITS   = 27;
  localparam int RD_BITS   = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_PRE, S_BLO, S_BSET, S_BHI, S_TLO, S_TURN,
    S_XHI, S_XLO, S_RPRE, S_RLO, S_RHI, S_RTLO, S_OFF
  } st_t;

  st_t               st, nst;
  logic [TW-1:0]     tmr;
  logic [5:0]        bcnt;
  logic              xcnt, mid, wr_q, tbl_q, a0_q, dat_q, rel_q;
  logic [FRAME_W-1:0] sh;
  logic [RD_BITS-1:0] rsh;
  logic              tick;

  assign tick      = (tmr == '0);
  assign req_ready = (st == S_IDLE);

  always_comb begin
    nst = st;
    if (st == S_IDLE) begin
      if (req_valid) nst = S_EN;
    end else if (tick) begin
      case (st)
        S_EN:   nst = S_PRE;
        S_PRE:  nst = S_BLO;
        S_BLO:  nst = S_BSET;
        S_BSET: nst = S_BHI;
        S_BHI:  nst = (bcnt == '0) ? S_TLO : S_BLO;
        S_TLO:  nst = wr_q ? S_XHI : S_TURN;
        S_TURN: nst = S_XHI;
        S_XHI:  nst = S_XLO;
        S_XLO:  nst = xcnt ? S_XHI : (mid ? S_RPRE : S_OFF);
        S_RPRE: nst = S_RLO;
        S_RLO:  nst = S_RHI;
        S_RHI:  nst = (bcnt == '0) ? S_RTLO : S_RLO;
        S_RTLO: nst = S_XHI;
        S_OFF:  nst = S_IDLE;
        default: nst = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      bcnt  <= '0;
      xcnt  <= 1'b0;
      mid   <= 1'b0;
      wr_q  <= 1'b0;
      tbl_q <= 1'b0;
      a0_q  <= 1'b0;
      dat_q <= 1'b0;
      rel_q <= 1'b0;
      sh    <= '0;
      rsh   <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      st   <= nst;
      done <= 1'b0;
      if (nst != st)
        tmr <= (nst == S_BSET) ? TW'(SETUP_CYC - 1) : TW'(EDGE_CYC - 1);
      else if (!tick)
        tmr <= tmr - 1'b1;

      if (st == S_IDLE && req_valid) begin
        wr_q  <= req_write;
        tbl_q <= req_table;
        a0_q  <= req_addr[0];
        dat_q <= 1'b0;
        rel_q <= 1'b0;
        if (req_write) begin
          sh   <= {3'b101, req_addr, req_wdata, 19'b0};
          bcnt <= 6'(WR_BITS - 1);
        end else begin
          sh   <= {32'hFFFF_FFFF, 4'b0110, req_table, 2'b00, req_addr[6:1], 1'b0};
          bcnt <= 6'(FRAME_W - 1);
        end
      end

      if (tick) begin
        case (st)
          S_BLO: dat_q <= sh[FRAME_W-1];
          S_BHI: begin
            sh   <= {sh[FRAME_W-2:0], 1'b0};
            bcnt <= bcnt - 1'b1;
          end
          S_TLO: begin
            xcnt <= 1'b1;
            mid  <= !wr_q;
            if (!wr_q) rel_q <= 1'b1;
          end
          S_XLO:  xcnt <= 1'b0;
          S_RPRE: begin
            bcnt <= 6'(RD_BITS - 1);
            mid  <= 1'b0;
          end
          S_RLO:  rsh <= {rsh[RD_BITS-2:0], sw_dat_i};
          S_RHI:  bcnt <= bcnt - 1'b1;
          S_RTLO: begin
            xcnt <= 1'b1;
            mid  <= 1'b0;
          end
          S_OFF: begin
            done  <= 1'b1;
            rdata <= tbl_q ? rsh : {16'b0, (a0_q ? rsh[31:16] : rsh[15:0])};
          end
          default: ;
        endcase
      end
    end
  end

  logic act, cs_d, clk_d;
  assign act   = (st != S_IDLE) && (st != S_OFF);
  assign cs_d  = wr_q && (st == S_PRE || st == S_BLO || st == S_BSET ||
                          st == S_BHI || st == S_TLO);
  assign clk_d = (st == S_BHI) || (st == S_XHI) || (st == S_RHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_cs_o   <= 1'b0;
      sw_cs_oe  <= 1'b0;
      sw_clk_o  <= 1'b0;
      sw_clk_oe <= 1'b0;
      sw_dat_o  <= 1'b0;
      sw_dat_oe <= 1'b0;
    end else begin
      sw_cs_o   <= cs_d;
      sw_cs_oe  <= act;
      sw_clk_o  <= clk_d;
      sw_clk_oe <= act;
      sw_dat_o  <= dat_q;
      sw_dat_oe <= act && !rel_q;
    end
  end
endmodule

module swreg_serial_master_chk #(
  parameter int EDGE_CYC  = 1,
  parameter int SETUP_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic done,
  input logic sw_cs_o,
  input logic sw_cs_oe,
  input logic sw_clk_o,
  input logic sw_clk_oe,
  input logic sw_dat_o,
  input logic sw_dat_oe
);
  logic        prev_clk, prev_dat, wr_lat;
  logic [15:0] hold_cnt, dat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      prev_dat <= 1'b0;
      wr_lat   <= 1'b0;
      hold_cnt <= 16'(EDGE_CYC);
      dat_cnt  <= 16'(SETUP_CYC);
    end else begin
      prev_clk <= sw_clk_o;
      prev_dat <= sw_dat_o;
      if (req_valid && req_ready) wr_lat <= req_write;
      if (sw_clk_o != prev_clk) hold_cnt <= 16'd1;
      else if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;
      if (sw_dat_o != prev_dat) dat_cnt <= 16'd1;
      else if (dat_cnt != 16'hFFFF) dat_cnt <= dat_cnt + 16'd1;
    end
  end

  p_cs_low_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !wr_lat) |-> !sw_cs_o);
  p_dat_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clk_o |-> $stable(sw_dat_o));
  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clk_oe && sw_clk_o != prev_clk) |-> (hold_cnt >= 16'(EDGE_CYC)));
  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_dat_oe && sw_clk_o && !prev_clk) |-> (dat_cnt >= 16'(SETUP_CYC)));
  p_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sw_cs_oe && !sw_clk_oe && !sw_dat_oe));
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind swreg_serial_master swreg_serial_master_chk #(
  .EDGE_CYC(EDGE_CYC), .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .done(done), .sw_cs_o(sw_cs_o), .sw_cs_oe(sw_cs_oe),
  .sw_clk_o(sw_clk_o), .sw_clk_oe(sw_clk_oe), .sw_dat_o(sw_dat_o),
  .sw_dat_oe(sw_dat_oe)
);

// File: tb/swreg_serial_master_bench.sv
`timescale 1ns/1ps
module swreg_serial_master_bench;
  localparam int CLK_PERIOD = 500;
  localparam int MHZ        = 2;
  localparam int EDGE       = 6;
  localparam int SETUP      = 2;
  localparam int NVEC       = 7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_table = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic        sw_cs_o, sw_cs_oe, sw_clk_o, sw_clk_oe, sw_dat_o, sw_dat_oe, sw_dat_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  swreg_serial_master #(.CLK_MHZ(MHZ)) u_swreg_serial_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_table(req_table), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .sw_cs_o(sw_cs_o), .sw_cs_oe(sw_cs_oe), .sw_clk_o(sw_clk_o),
    .sw_clk_oe(sw_clk_oe), .sw_dat_o(sw_dat_o), .sw_dat_oe(sw_dat_oe),
    .sw_dat_i(sw_dat_i)
  );

  // slave model and edge recorder
  logic        mon_clr = 1'b0;
  logic [31:0] slave_word = '0;
  int          rcnt = 0;
  logic        rec_dat [128];
  logic        rec_cs  [128];
  logic        rec_oe  [128];
  logic        prev_clk = 1'b0, prev_dat = 1'b0;
  int          run_len = 100000, dcnt = 100000;
  int          min_half = 100000, min_setup = 100000;

  assign sw_dat_i = (rcnt >= 48 && rcnt < 80) ? slave_word[79 - rcnt] : 1'b1;

  always @(posedge clk) begin
    if (mon_clr) rcnt <= 0;
    else if (sw_clk_oe && sw_clk_o && !prev_clk) begin
      if (rcnt < 128) begin
        rec_dat[rcnt] <= sw_dat_o;
        rec_cs[rcnt]  <= sw_cs_o;
        rec_oe[rcnt]  <= sw_dat_oe;
      end
      rcnt <= rcnt + 1;
      if (sw_dat_oe && dcnt < min_setup) min_setup <= dcnt;
    end
    if (sw_clk_o != prev_clk) begin
      if (sw_clk_oe && run_len < min_half) min_half <= run_len;
      run_len <= 1;
    end else run_len <= run_len + 1;
    if (sw_dat_o != prev_dat) dcnt <= 1; else dcnt <= dcnt + 1;
    prev_clk <= sw_clk_o;
    prev_dat <= sw_dat_o;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic check_frame(input logic wr, input logic tbl, input logic [7:0] addr,
                             input logic [15:0] wdata);
    logic [26:0] wf;
    logic [45:0] rf;
    int bad, first, cs_hi, oe_bad;
    wf = {3'b101, addr, wdata};
    rf = {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, addr[6:1], 1'b0};
    bad = 0; first = -1; cs_hi = 0; oe_bad = 0;
    for (int i = 0; i < 82; i++) if (i < rcnt && rec_cs[i]) cs_hi++;
    if (wr) begin
      for (int i = 0; i < 27; i++)
        if (rec_dat[i] !== wf[26-i]) begin bad++; if (first < 0) first = i; end
      check(bad == 0, "R1 write frame bits (first bad index)", first, -1);
      check(cs_hi == 27 && rec_cs[26] === 1'b1, "R1 cs-high rising edges", cs_hi, 27);
      check(rcnt == 29, "R7 write rising edges", rcnt, 29);
    end else begin
      for (int i = 0; i < 46; i++)
        if (rec_dat[i] !== rf[45-i]) begin bad++; if (first < 0) first = i; end
      check(bad == 0, "R2 read frame bits (first bad index)", first, -1);
      check(cs_hi == 0, "R2 cs stays low on read", cs_hi, 0);
      for (int i = 0; i < 82; i++)
        if (rec_oe[i] !== (i < 46)) oe_bad++;
      check(oe_bad == 0, "R5 data released after command", oe_bad, 0);
      check(rcnt == 82, "R7 read rising edges", rcnt, 82);
    end
  endtask

  task automatic run_xfer(input logic wr, input logic tbl, input logic [7:0] addr,
                          input logic [15:0] wdata, input logic [31:0] word);
    logic [31:0] exp;
    @(negedge clk);
    slave_word = word; mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    check(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_table = tbl; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
    wait_done();
    check(!sw_cs_oe && !sw_clk_oe && !sw_dat_oe, "R7 outputs released at done",
          {sw_cs_oe, sw_clk_oe, sw_dat_oe}, 0);
    if (!wr) begin
      exp = tbl ? word : {16'b0, (addr[0] ? word[31:16] : word[15:0])};
      if (tbl) check(rdata == exp, "R6 counter read data", rdata, exp);
      else     check(rdata == exp, "R5 register read data", rdata, exp);
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done is one cycle", done, 0);
    check_frame(wr, tbl, addr, wdata);
  endtask

  // {write, table, addr, wdata, slave word}
  localparam logic [57:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h5A, 16'hC3A5, 32'h0},
    {1'b1, 1'b0, 8'h01, 16'h0000, 32'h0},
    {1'b1, 1'b0, 8'hFF, 16'hFFFF, 32'h0},
    {1'b0, 1'b0, 8'h13, 16'h0000, 32'h1234_ABCD},
    {1'b0, 1'b0, 8'h22, 16'h0000, 32'h89EF_0F0F},
    {1'b0, 1'b1, 8'h3C, 16'h0000, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 8'h7F, 16'h0000, 32'h8000_0001}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!sw_cs_oe && !sw_clk_oe && !sw_dat_oe, "R9 enables low in reset",
          {sw_cs_oe, sw_clk_oe, sw_dat_oe}, 0);
    check(req_ready == 1'b1 && done == 1'b0, "R9 ready high done low in reset",
          {req_ready, done}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_xfer(VEC[v][57], VEC[v][56], VEC[v][55:48], VEC[v][47:32], VEC[v][31:0]);

    // R4 measured timing
    check(min_half >= EDGE, "R4 minimum clock phase", min_half, EDGE);
    check(min_setup >= SETUP, "R4 minimum data setup", min_setup, SETUP);

    // R8 request offered while busy is ignored
    @(negedge clk);
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hA6; req_wdata = 16'h1357;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_table = 1'b1; req_addr = 8'h05;
    repeat (3) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R8 not ready while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
    check_frame(1'b1, 1'b0, 8'hA6, 16'h1357);
    repeat (300) @(negedge clk);
    check(rcnt == 29 && !sw_clk_oe, "R8 busy request ignored", rcnt, 29);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule